// File: doc/BRIEF.md
# Multichannel Sample Bias and Range Select

This block post-processes digitized video samples from several parallel converter channels. On every pixel cycle each channel delivers one 16-bit sample. The block subtracts a programmable bias from each sample at the full input width. A result below zero is clamped to zero. The block then discards the two least significant bits and emits a 12-bit code taken from one of two windows of the remaining 14 bits.

The high window keeps the coarse, full-scale view of the signal. The low window keeps fine resolution for small signals. In the low window, a result that does not fit saturates to all ones and raises a per-channel overflow flag.

The biases and the window mode are written through a simple register write port. A write lands in a configuration register that a sample reads when it is captured, so a sample never sees a half-applied setting. Samples enter with a valid strobe and leave two clock edges later with their own valid strobe. There is no backpressure.

Top module: `sample_bias_range`

## Requirements
- R1: After reset `out_valid` is 0, every `out_samples` lane and every `out_ovf` bit are 0, all biases are 0 and the window mode is low window.
- R2: A sample set captured at clock edge k (`in_valid` = 1) appears on the outputs after edge k+1 with `out_valid` = 1. A cycle with `in_valid` = 0 gives `out_valid` = 0 two edges later.
- R3: For each channel the bias is subtracted from the sample at full 16-bit width, and only then are the two least significant bits of the difference dropped, leaving a 14-bit value.
- R4: When a channel's sample is smaller than its bias, the difference is clamped to 0 and that lane outputs 0 with no overflow flag.
- R5: In high-window mode (mode bit = 1) a lane outputs bits [15:4] of the clamped difference and its overflow flag is 0.
- R6: In low-window mode (mode bit = 0) a lane whose clamped difference is below 0x4000 outputs bits [13:2] of that difference with overflow flag 0.
- R7: In low-window mode a lane whose clamped difference is 0x4000 or more outputs 0xFFF and raises its overflow flag. The flag always travels with the sample it describes.
- R8: Configuration write addresses: address c (0 to 3) writes the 16-bit bias of channel c (lane c is `in_samples[16c+15:16c]`), and address 4 writes the window mode from `cfg_wdata[0]`. Each channel uses only its own bias.
- R9: A configuration write at edge k affects only samples captured at edges after k. A sample captured at the same edge as a write uses the previous setting.
- R10: Writes to addresses 5, 6 and 7 change no bias and no mode.
- R11: While `out_valid` is 0, `out_samples` and `out_ovf` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample set on `in_samples` is valid this cycle |
| in_samples | input | 64 | Four 16-bit samples, lane c at bits [16c+15:16c] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 to 3 bias, 4 mode) |
| cfg_wdata | input | 16 | Configuration write data |
| out_valid | output | 1 | Output set is valid this cycle |
| out_samples | output | 48 | Four 12-bit codes, lane c at bits [12c+11:12c] |
| out_ovf | output | 4 | Per-lane low-window saturation flag |

## Verification
Directed sample sets place the clamped difference just below, at and above the 0x4000 saturation boundary and just below and at the bias, so that clamping, window choice and the two dropped bits are told apart. Distinct biases on the four lanes, including 0 and 0xFFFF, separate a lane that uses a neighbour's bias or a wrong address decode from a correct one. A write issued in the same cycle as a sample, and writes to unused addresses, show when a setting takes effect and that aliases do not exist. Long random streams with gaps in `in_valid` and scattered writes exercise the latency, the hold behaviour and mixed modes against a bench arithmetic model.

// File: rtl/sbr_pkg.sv
// Shared types for the sample bias and range select block.
// Assumes: the window mode is a single bit written by software.
package sbr_pkg;

    // Output window inside the retained bits of the difference
    typedef enum logic {
        WIN_LOW  = 1'b0,
        WIN_HIGH = 1'b1
    } win_t;

endpackage

// File: rtl/sbr_cfg_regs.sv
// Configuration register file: one bias per channel plus the window mode.
// Address c (c < NUM_CH) writes the bias of channel c, and address NUM_CH
// writes the mode from wdata bit 0. Other addresses are ignored.
// Assumes: ADDR_W is wide enough to encode NUM_CH.
module sbr_cfg_regs
    import sbr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [NUM_CH*DATA_W-1:0] bias_flat,
    output win_t                     win
);

    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bias
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(c);
        logic [DATA_W-1:0] bias_q;

        // Hold the bias of channel c, loaded by a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bias_q <= '0;
            end else if (cfg_we && cfg_addr == MY_ADDR) begin
                bias_q <= cfg_wdata;
            end
        end

        assign bias_flat[c*DATA_W +: DATA_W] = bias_q;
    end

    // Hold the window mode, loaded by a write to the mode address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= WIN_LOW;
        end else if (cfg_we && cfg_addr == MODE_ADDR) begin
            win <= win_t'(cfg_wdata[0]);
        end
    end

endmodule

// File: rtl/sbr_sub_stage.sv
// First pipeline stage of one lane: subtract the bias at full width and
// clamp a negative result to zero. The register loads only on a sample.
// Assumes: sample and bias are unsigned and of equal width.
module sbr_sub_stage #(
    parameter int IN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [IN_W-1:0] sample,
    input  logic [IN_W-1:0] bias,
    output logic [IN_W-1:0] diff_q
);

    logic [IN_W:0]   wide_diff;
    logic            borrow;
    logic [IN_W-1:0] clamped;

    // Unsigned subtraction with one extra bit to expose the borrow
    always_comb begin
        wide_diff = {1'b0, sample} - {1'b0, bias};
        borrow    = wide_diff[IN_W];
        clamped   = borrow ? '0 : wide_diff[IN_W-1:0];
    end

    // Register the clamped difference when a sample is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
        end else if (load) begin
            diff_q <= clamped;
        end
    end

endmodule

// File: rtl/sbr_window_stage.sv
// Second pipeline stage of one lane: drop DROP_W low bits and select the
// high or low OUT_W-bit window of what remains. In the low window a value
// with any of the top head bits set saturates and raises the flag.
// Assumes: IN_W - DROP_W > OUT_W.
module sbr_window_stage
    import sbr_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int DROP_W = 2,
    parameter int OUT_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IN_W-1:0]  diff,
    input  win_t             win,
    output logic [OUT_W-1:0] code_q,
    output logic             ovf_q
);

    localparam int KEEP_W = IN_W - DROP_W;
    localparam int HEAD_W = KEEP_W - OUT_W;

    logic [KEEP_W-1:0] kept;
    logic              head_set;
    logic [OUT_W-1:0]  code_d;
    logic              ovf_d;

    // Pick the window and apply low-window saturation
    always_comb begin
        kept     = diff[IN_W-1:DROP_W];
        head_set = |kept[KEEP_W-1 -: HEAD_W];
        if (win == WIN_HIGH) begin
            code_d = kept[KEEP_W-1 -: OUT_W];
            ovf_d  = 1'b0;
        end else if (head_set) begin
            code_d = '1;
            ovf_d  = 1'b1;
        end else begin
            code_d = kept[OUT_W-1:0];
            ovf_d  = 1'b0;
        end
    end

    // Register code and flag together so they stay aligned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            ovf_q  <= 1'b0;
        end else if (load) begin
            code_q <= code_d;
            ovf_q  <= ovf_d;
        end
    end

endmodule

// File: rtl/sample_bias_range.sv
// Multichannel sample bias and range select, top level.
// Stage 1 subtracts each lane's bias and samples the window mode. Stage 2
// truncates the difference and selects the output window. The valid strobe
// moves with the data. Configuration is read when a sample is captured,
// so a write never splits a sample. There is no backpressure.
module sample_bias_range
    import sbr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IN_W   = 16,
    parameter int DROP_W = 2,
    parameter int OUT_W  = 12,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NUM_CH*IN_W-1:0]  in_samples,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [IN_W-1:0]         cfg_wdata,
    output logic                    out_valid,
    output logic [NUM_CH*OUT_W-1:0] out_samples,
    output logic [NUM_CH-1:0]       out_ovf
);

    logic [NUM_CH*IN_W-1:0] bias_flat;
    win_t                   win_cfg;
    win_t                   win_s1;
    logic                   valid_s1;

    sbr_cfg_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (IN_W),
        .ADDR_W (ADDR_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bias_flat (bias_flat),
        .win       (win_cfg)
    );

    // Move the valid strobe through both stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_s1  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            valid_s1  <= in_valid;
            out_valid <= valid_s1;
        end
    end

    // Take a copy of the mode with each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_s1 <= WIN_LOW;
        end else if (in_valid) begin
            win_s1 <= win_cfg;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic [IN_W-1:0] diff_s1;

        sbr_sub_stage #(
            .IN_W (IN_W)
        ) i_sub (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (in_valid),
            .sample (in_samples[c*IN_W +: IN_W]),
            .bias   (bias_flat[c*IN_W +: IN_W]),
            .diff_q (diff_s1)
        );

        sbr_window_stage #(
            .IN_W   (IN_W),
            .DROP_W (DROP_W),
            .OUT_W  (OUT_W)
        ) i_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (valid_s1),
            .diff   (diff_s1),
            .win    (win_s1),
            .code_q (out_samples[c*OUT_W +: OUT_W]),
            .ovf_q  (out_ovf[c])
        );
    end

endmodule

// File: rtl/sample_bias_range_chk.sv
// Checker for sample_bias_range: latency of the valid strobe, the
// saturation code and output hold. It is attached with a bind statement.
module sample_bias_range_chk #(
    parameter int NUM_CH = 4,
    parameter int OUT_W  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic [NUM_CH*OUT_W-1:0] out_samples,
    input logic [NUM_CH-1:0]       out_ovf
);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R11
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_samples) && $stable(out_ovf)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sat
        // R7
        sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_ovf[c]) |-> (out_samples[c*OUT_W +: OUT_W] == {OUT_W{1'b1}}));
    end

endmodule

bind sample_bias_range sample_bias_range_chk #(
    .NUM_CH (NUM_CH),
    .OUT_W  (OUT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_samples (out_samples),
    .out_ovf     (out_ovf)
);

// File: tb/test_sample_bias_range.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random streams,
// compared each cycle against a bench arithmetic model.
module test_sample_bias_range;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_samples = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        out_valid;
    logic [47:0] out_samples;
    logic [3:0]  out_ovf;

    int vectors = 0;
    int fails   = 0;

    // Bench model state
    logic [15:0] m_bias [4];
    bit          m_hi;
    bit          p1_v, p2_v;
    logic [11:0] p1_d [4], p2_d [4], h_d [4];
    bit          p1_o [4], p2_o [4], h_o [4];
    string       p1_t [4], p2_t [4];
    string       p1_ctx, p2_ctx;

    always #10 clk = ~clk;

    sample_bias_range i_sample_bias_range (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_samples  (in_samples),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .out_valid   (out_valid),
        .out_samples (out_samples),
        .out_ovf     (out_ovf)
    );

    // Expected code of one lane, computed from the requirements
    function automatic void ref_lane(input logic [15:0] s, input logic [15:0] b,
                                     input bit hi, output logic [11:0] o,
                                     output bit ov, output string tg);
        logic [15:0] d;
        logic [13:0] k;
        if (s < b) begin
            d  = 16'h0000;              // R4 clamp
            tg = "R4";
        end else begin
            d  = s - b;                 // R3 full-width subtraction
            tg = hi ? "R5" : "R6";
        end
        k  = d[15:2];
        ov = 1'b0;
        if (hi) begin
            o = k[13:2];
        end else if (k[13:12] != 2'b00) begin
            o  = 12'hFFF;               // R7 saturation
            ov = 1'b1;
            tg = "R7";
        end else begin
            o = k[11:0];
        end
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // One cycle: check the outputs, then drive new inputs and advance the model
    task automatic step(input bit v, input logic [63:0] smp, input bit we,
                        input logic [2:0] a, input logic [15:0] wd, input string ctx);
        logic [11:0] eo;
        bit          eov;
        string       tg;
        @(negedge clk);
        vectors++;
        if (out_valid !== p2_v) begin
            fails++;
            $display("FAIL R2 [%s] out_valid got %b exp %b", ctx, out_valid, p2_v);
        end
        for (int c = 0; c < 4; c++) begin
            logic [11:0] xd;
            bit          xo;
            string       xt;
            xd = p2_v ? p2_d[c] : h_d[c];
            xo = p2_v ? p2_o[c] : h_o[c];
            xt = p2_v ? p2_t[c] : "R11";
            vectors++;
            if (out_samples[c*12 +: 12] !== xd || out_ovf[c] !== xo) begin
                fails++;
                $display("FAIL %s [%s] lane %0d got %h/%b exp %h/%b", xt,
                         p2_v ? p2_ctx : ctx, c, out_samples[c*12 +: 12],
                         out_ovf[c], xd, xo);
            end
        end
        if (p2_v) begin
            for (int c = 0; c < 4; c++) begin
                h_d[c] = p2_d[c];
                h_o[c] = p2_o[c];
            end
        end
        p2_v   = p1_v;
        p2_ctx = p1_ctx;
        for (int c = 0; c < 4; c++) begin
            p2_d[c] = p1_d[c];
            p2_o[c] = p1_o[c];
            p2_t[c] = p1_t[c];
        end
        p1_v   = v;
        p1_ctx = ctx;
        if (v) begin
            for (int c = 0; c < 4; c++) begin
                ref_lane(smp[c*16 +: 16], m_bias[c], m_hi, eo, eov, tg);
                p1_d[c] = eo;
                p1_o[c] = eov;
                p1_t[c] = tg;
            end
        end
        // R9: the model applies a write after the sample of the same cycle
        if (we) begin
            if (a < 3'd4) m_bias[a[1:0]] = wd;      // R8
            else if (a == 3'd4) m_hi = wd[0];       // R8
            // R10: addresses 5 to 7 leave the model untouched
        end
        in_valid   = v;
        in_samples = smp;
        cfg_we     = we;
        cfg_addr   = a;
        cfg_wdata  = wd;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin
            m_bias[c] = '0;
            h_d[c] = '0; h_o[c] = 1'b0;
            p1_d[c] = '0; p2_d[c] = '0; p1_o[c] = 1'b0; p2_o[c] = 1'b0;
            p1_t[c] = ""; p2_t[c] = "";
        end
        m_hi = 1'b0; p1_v = 1'b0; p2_v = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (out_valid !== 1'b0 || out_samples !== '0 || out_ovf !== '0) begin
            fails++;
            $display("FAIL R1 reset got %b/%h/%b exp 0/0/0", out_valid, out_samples, out_ovf);
        end
        rst_n = 1'b1;

        // R1: default biases 0 and low window; boundary values around 0x4000
        step(1, {16'hFFFF, 16'h4000, 16'h3FFF, 16'h0003}, 0, 0, 0, "R1 defaults");
        step(1, {16'hFFFC, 16'h3FFC, 16'h0004, 16'h0000}, 0, 0, 0, "R6 boundary");
        // R8: distinct biases per lane
        step(0, '0, 1, 3'd0, 16'h0100, "R8 bias0");
        step(0, '0, 1, 3'd1, 16'h8000, "R8 bias1");
        step(0, '0, 1, 3'd2, 16'hFFFF, "R8 bias2");
        step(0, '0, 1, 3'd3, 16'h0004, "R8 bias3");
        step(1, {16'h0107, 16'hFFFE, 16'h8000, 16'h1234}, 0, 0, 0, "R8 lanes");
        step(1, {16'h4004, 16'hFFFF, 16'h7FFF, 16'h00FF}, 0, 0, 0, "R4 underflow");
        // R9: mode write in the same cycle as a sample
        step(1, {16'hC000, 16'hFFFF, 16'hC000, 16'hF100}, 1, 3'd4, 16'h0001, "R9 same edge");
        step(1, {16'hC000, 16'hFFFF, 16'hC000, 16'hF100}, 0, 0, 0, "R9 after write");
        step(1, {16'h0013, 16'hFFFF, 16'h8013, 16'h0113}, 0, 0, 0, "R5 high window");
        // R10: unmapped writes, data chosen to expose aliasing
        step(0, '0, 1, 3'd5, 16'h0000, "R10 addr5");
        step(0, '0, 1, 3'd6, 16'hAAAA, "R10 addr6");
        step(0, '0, 1, 3'd7, 16'h5555, "R10 addr7");
        step(1, {16'h4004, 16'hFFFF, 16'hC000, 16'h8100}, 0, 0, 0, "R10 check");
        // R11: idle cycles hold the last outputs
        step(0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R11 idle");
        step(0, '0, 0, 0, 0, "R11 idle");
        step(0, '0, 0, 0, 0, "R11 idle");
        // Back to low window; R3 dropped bits
        step(0, '0, 1, 3'd4, 16'hFFFE, "R6 mode low");
        step(1, {16'h4007, 16'hFFFF, 16'h8003, 16'h0103}, 0, 0, 0, "R3 drop bits");

        // Random traffic with scattered writes
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] smp;
            bit          v, we;
            smp = {$urandom(), $urandom()};
            if ($urandom() % 4 == 0) smp[15:0] = m_bias[0] + 16'($urandom() % 8);
            v  = ($urandom() % 4) != 0;
            we = ($urandom() % 10) == 0;
            step(v, smp, we, 3'($urandom() % 8), 16'($urandom()), "R3 random");
        end
        repeat (3) step(0, '0, 0, 0, 0, "R11 drain");
        summary();
    end

endmodule